// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with Output Polarity Control

This block sits behind a bank of comparators in a flash converter. It takes the thermometer vector that the comparators produce, together with one extra full-scale comparator, and turns them into a registered binary step number and an overrange indication. The thermometer has 2**CODE_W-1 bits. Comparator k, counted from 1, arrives on `therm_i[k-1]`. The step number is the index of the highest comparator that is set, once a single-bubble filter has been applied. An all-clear vector gives step 0.

Two static inputs choose how the step number is coded on the outputs. `flip_top_i` inverts only the most significant bit. `flip_low_i` inverts all the lower bits. Together they give plain binary, offset two's-complement style, low-bits-inverted and fully inverted coding. Every data bit and the overrange flag leave the block as a true/complement pair. The true overrange output is active-low, and neither polarity input changes it. Integration should tie the polarity inputs low when they are unused, which selects plain binary.

There are two register stages: a capture register for the comparator vector and an output register. A sample captured at one clock edge therefore reaches the outputs after the next edge.

Top module: `thermo_bin_encoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs take their reset values on that edge: `dat_t_o` = 0x00, `dat_c_o` = 0xFF, `ovr_t_o` = 1, `ovr_c_o` = 0.
- R2: Inputs present before rising edge N are captured on edge N. Their result appears on all outputs after edge N+1, and the outputs do not change after edge N alone.
- R3: With both polarity inputs low and no overrange, `dat_t_o` equals the highest qualified comparator index. Bit `therm_i[k-1]` stands for comparator k. An all-zero vector gives 0x00 and an all-ones vector gives 0xFF.
- R4: Comparator k (k ≥ 2) counts only if comparator k-1 is also set, so an isolated 1 sitting above a 0 is ignored. Comparator 1 counts whenever it is set.
- R5: With `flip_top_i` high and `flip_low_i` low, only bit 7 is inverted: step 127 reads 0xFF and step 128 reads 0x00.
- R6: With `flip_low_i` high and `flip_top_i` low, bits 6..0 are inverted: step 0 reads 0x7F and step 255 reads 0x80.
- R7: With both polarity inputs high, all bits are inverted: step 0 reads 0xFF and step 255 reads 0x00.
- R8: When `over_cmp_i` is high, `ovr_t_o` is 0 and `ovr_c_o` is 1, whatever the polarity inputs are. Otherwise `ovr_t_o` is 1 and `ovr_c_o` is 0.
- R9: During overrange the data saturates to the step-255 code after polarity is applied: 0xFF, 0x7F, 0x80 or 0x00 for (top, low) = 00, 10, 01 and 11. This holds regardless of the thermometer vector.
- R10: On every cycle `dat_c_o` is the bitwise inverse of `dat_t_o`, and `ovr_c_o` is the inverse of `ovr_t_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| therm_i | input | 255 | Comparator thermometer; bit k-1 is comparator k |
| over_cmp_i | input | 1 | Full-scale comparator, high when the input is above range |
| flip_top_i | input | 1 | Static: invert the most significant output bit |
| flip_low_i | input | 1 | Static: invert the seven lower output bits |
| dat_t_o | output | 8 | Coded step number, true polarity |
| dat_c_o | output | 8 | Complement of `dat_t_o` |
| ovr_t_o | output | 1 | Overrange flag, true output, low when over range |
| ovr_c_o | output | 1 | Complement of `ovr_t_o`, high when over range |

## Verification
Some properties are checked by assertions on every cycle:
- the output pairs stay complementary;
- an overrange flag always comes with the saturated, polarity-coded full-scale word;
- the overrange flag follows the full-scale comparator exactly two edges later;
- the priority encoder returns 0 for an empty vector and otherwise points at a qualified comparator.

Other behaviours can only be shown by the bench's scenarios:
- that the chosen index is the highest one;
- that bubbles are rejected;
- the exact codes at steps 0, 127, 128 and 255 under each of the four polarity settings;
- the one-edge hold before new data appears.

// File: rtl/thermenc_pkg.sv
// Package: shared types for the thermometer encoder.
// Assumes: polarity selections are static with respect to the data path.
package thermenc_pkg;

    // Output polarity selection
    typedef struct packed {
        logic flip_top;   // invert most significant bit
        logic flip_low;   // invert all lower bits
    } pol_t;

endpackage

// File: rtl/therm_capture.sv
// Module: therm_capture
// Captures the comparator thermometer and the full-scale comparator on
// every rising edge. Assumes inputs settle before the edge.
module therm_capture #(
    parameter int unsigned N = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] therm_d,
    input  logic         over_d,
    output logic [N-1:0] therm_q,
    output logic         over_q
);

    // Capture stage: clear on reset, otherwise follow the comparators
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            therm_q <= '0;
            over_q  <= 1'b0;
        end else begin
            therm_q <= therm_d;
            over_q  <= over_d;
        end
    end

endmodule

// File: rtl/therm_bubble_fix.sv
// Module: therm_bubble_fix
// Qualifies each comparator bit: bit k counts only when bit k-1 is also
// set, which removes a lone 1 sitting above a 0. The lowest comparator
// has no neighbour below and is taken as-is.
module therm_bubble_fix #(
    parameter int unsigned N = 255
) (
    input  logic [N-1:0] therm,
    output logic [N-1:0] qual
);

    // Per-bit qualification against the neighbour below
    for (genvar k = 0; k < int'(N); k++) begin : g_q
        if (k == 0) begin : g_base
            assign qual[k] = therm[k];
        end else begin : g_up
            assign qual[k] = therm[k] & therm[k-1];
        end
    end

endmodule

// File: rtl/therm_prio_enc.sv
// Module: therm_prio_enc
// Returns the 1-based index of the highest set bit of the qualified
// vector, or 0 when no bit is set. Assumes N = 2**W - 1.
module therm_prio_enc #(
    parameter int unsigned N = 255,
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] qual,
    output logic [W-1:0] idx
);

    // Highest-index search; the later loop hit wins
    always_comb begin
        idx = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (qual[i]) idx = W'(i + 1);
        end
    end

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (qual == '0) |-> (idx == '0)); // R3
    AST_TOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0) |-> qual[idx - W'(1)]); // R4

endmodule

// File: rtl/code_out_stage.sv
// Module: code_out_stage
// Saturates the step on overrange, applies the polarity mask and
// registers the true and complement outputs. The overrange pair is not
// affected by polarity. Assumes polarity inputs are static.
module code_out_stage
    import thermenc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] step,
    input  logic         over,
    input  pol_t         pol,
    output logic [W-1:0] dat_t,
    output logic [W-1:0] dat_c,
    output logic         ovr_t,
    output logic         ovr_c
);

    logic [W-1:0] mask;
    logic [W-1:0] sat;
    logic [W-1:0] coded;

    // Polarity mask, saturation and coding
    always_comb begin
        mask  = {pol.flip_top, {(W-1){pol.flip_low}}};
        sat   = over ? '1 : step;
        coded = sat ^ mask;
    end

    // Output register with separately held true and complement copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_t <= '0;
            dat_c <= '1;
            ovr_t <= 1'b1;
            ovr_c <= 1'b0;
        end else begin
            dat_t <= coded;
            dat_c <= ~coded;
            ovr_t <= ~over;
            ovr_c <= over;
        end
    end

    AST_SAT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_c |-> (dat_t == ~$past(mask))); // R9

endmodule

// File: rtl/thermo_bin_encoder.sv
// Module: thermo_bin_encoder (top)
// Thermometer-to-binary encoder: capture, bubble filter, priority encode,
// polarity/saturation and output register. Two-edge latency from input
// to output. Assumes thermometer width is 2**CODE_W - 1.
module thermo_bin_encoder
    import thermenc_pkg::*;
#(
    parameter int unsigned CODE_W = 8,
    localparam int unsigned LEVELS = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] therm_i,
    input  logic              over_cmp_i,
    input  logic              flip_top_i,
    input  logic              flip_low_i,
    output logic [CODE_W-1:0] dat_t_o,
    output logic [CODE_W-1:0] dat_c_o,
    output logic              ovr_t_o,
    output logic              ovr_c_o
);

    logic [LEVELS-1:0] therm_cap;
    logic              over_cap;
    logic [LEVELS-1:0] qual;
    logic [CODE_W-1:0] step;
    pol_t              pol;

    assign pol = '{flip_top: flip_top_i, flip_low: flip_low_i};

    therm_capture #(.N(LEVELS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .therm_d (therm_i),
        .over_d  (over_cmp_i),
        .therm_q (therm_cap),
        .over_q  (over_cap)
    );

    therm_bubble_fix #(.N(LEVELS)) u_bub (
        .therm (therm_cap),
        .qual  (qual)
    );

    therm_prio_enc #(.N(LEVELS), .W(CODE_W)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .qual  (qual),
        .idx   (step)
    );

    code_out_stage #(.W(CODE_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .over  (over_cap),
        .pol   (pol),
        .dat_t (dat_t_o),
        .dat_c (dat_c_o),
        .ovr_t (ovr_t_o),
        .ovr_c (ovr_c_o)
    );

    // Cycles since reset release, saturating at 2 (for the latency check)
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_c_o == ~dat_t_o) && (ovr_c_o == ~ovr_t_o)); // R10
    AST_OVR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (ovr_c_o == $past(over_cmp_i, 2))); // R2

endmodule

// File: tb/sim_thermo_bin_encoder.sv
`timescale 1ns/1ps
module sim_thermo_bin_encoder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [254:0] therm_i = '0;
    logic         over_cmp_i = 1'b0;
    logic         flip_top_i = 1'b0;
    logic         flip_low_i = 1'b0;
    logic [7:0]   dat_t_o, dat_c_o;
    logic         ovr_t_o, ovr_c_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    thermo_bin_encoder u0 (
        .clk(clk), .rst_n(rst_n), .therm_i(therm_i), .over_cmp_i(over_cmp_i),
        .flip_top_i(flip_top_i), .flip_low_i(flip_low_i),
        .dat_t_o(dat_t_o), .dat_c_o(dat_c_o), .ovr_t_o(ovr_t_o), .ovr_c_o(ovr_c_o)
    );

    // lvl: comparators 1..lvl set; bub: one extra set comparator (0 = none)
    typedef struct packed {
        logic [7:0] lvl;
        logic [7:0] bub;
        logic       ov;
        logic       top;
        logic       low;
        logic [7:0] exp_dat;
        logic       exp_ovt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{8'd0,   8'd0,   1'b0, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 empty
        '{8'd255, 8'd0,   1'b0, 1'b0, 1'b0, 8'hFF, 1'b1}, // R3 full
        '{8'd100, 8'd0,   1'b0, 1'b0, 1'b0, 8'h64, 1'b1}, // R3 mid
        '{8'd127, 8'd0,   1'b0, 1'b1, 1'b0, 8'hFF, 1'b1}, // R5
        '{8'd128, 8'd0,   1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R5
        '{8'd0,   8'd0,   1'b0, 1'b0, 1'b1, 8'h7F, 1'b1}, // R6
        '{8'd255, 8'd0,   1'b0, 1'b0, 1'b1, 8'h80, 1'b1}, // R6
        '{8'd0,   8'd0,   1'b0, 1'b1, 1'b1, 8'hFF, 1'b1}, // R7
        '{8'd255, 8'd0,   1'b0, 1'b1, 1'b1, 8'h00, 1'b1}, // R7
        '{8'd50,  8'd0,   1'b0, 1'b1, 1'b1, 8'hCD, 1'b1}, // R7
        '{8'd40,  8'd60,  1'b0, 1'b0, 1'b0, 8'h28, 1'b1}, // R4 lone 1 ignored
        '{8'd0,   8'd1,   1'b0, 1'b0, 1'b0, 8'h01, 1'b1}, // R4 comparator 1
        '{8'd0,   8'd200, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1}, // R4 lone 1 on empty
        '{8'd255, 8'd0,   1'b1, 1'b0, 1'b0, 8'hFF, 1'b0}, // R8 R9
        '{8'd255, 8'd0,   1'b1, 1'b1, 1'b0, 8'h7F, 1'b0}, // R8 R9
        '{8'd255, 8'd0,   1'b1, 1'b0, 1'b1, 8'h80, 1'b0}, // R8 R9
        '{8'd255, 8'd0,   1'b1, 1'b1, 1'b1, 8'h00, 1'b0}, // R8 R9
        '{8'd10,  8'd0,   1'b1, 1'b0, 1'b0, 8'hFF, 1'b0}  // R9 saturation
    };

    function automatic logic [254:0] mk_therm(int lvl, int bub);
        logic [254:0] t = '0;
        for (int i = 0; i < lvl; i++) t[i] = 1'b1;
        if (bub != 0) t[bub-1] = 1'b1;
        return t;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check the outputs against an expected word and flag, including pairs
    task automatic chk_out(string req, logic [7:0] ed, logic eo);
        chk(req, {24'd0, dat_t_o}, {24'd0, ed});
        chk({req, " R10 data pair"}, {24'd0, dat_c_o}, {24'd0, ~ed});
        chk({req, " R8 flag"}, {30'd0, ovr_t_o, ovr_c_o}, {30'd0, eo, ~eo});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state with busy inputs
        therm_i = '1;
        over_cmp_i = 1'b1;
        flip_top_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_out("R1 reset", 8'h00, 1'b1);
        rst_n = 1'b1;
        over_cmp_i = 1'b0;
        flip_top_i = 1'b0;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            therm_i    = mk_therm(int'(TBL[v].lvl), int'(TBL[v].bub));
            over_cmp_i = TBL[v].ov;
            flip_top_i = TBL[v].top;
            flip_low_i = TBL[v].low;
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            chk_out($sformatf("R3 R5 R6 R7 R9 vector %0d", v), TBL[v].exp_dat, TBL[v].exp_ovt);
        end

        // R2: one-edge hold, then new data
        flip_top_i = 1'b0;
        flip_low_i = 1'b0;
        over_cmp_i = 1'b0;
        therm_i = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        therm_i = mk_therm(5, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 hold after capture edge", {24'd0, dat_t_o}, 32'h0);
        therm_i = mk_therm(9, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 data after second edge", {24'd0, dat_t_o}, 32'h5);
        @(posedge clk);
        @(negedge clk);
        chk("R2 streaming next sample", {24'd0, dat_t_o}, 32'h9);

        // R4: a set comparator with its lower neighbour clear in mid-vector
        therm_i = mk_therm(78, 80);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4 hole below top bit", {24'd0, dat_t_o}, 32'd78);

        // R1: reset in mid-run overrides nonzero state
        over_cmp_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_out("R1 mid-run reset", 8'h00, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_out("R8 R9 after reset release", 8'hFF, 1'b0);

        finish_run();
    end

endmodule